// File: doc/BRIEF.md
# Vectored Nested-Priority Interrupt Controller

This block collects 32 interrupt request lines and presents one active-low interrupt request to a processor. A small word-addressed register bus configures each source: a mode word holds a 3-bit priority and a trigger type, and a vector word holds the value to return on acknowledge. Sources are unmasked and masked through command words where each bit set to one acts on the matching source. Sources are forced pending or cleared through a second pair of command words built the same way.

The processor acknowledges by reading the vector word. That read returns the vector of the winning source: the highest priority among pending, unmasked sources, with the lowest source number breaking ties. The same read pushes the winner's priority and number onto an 8-level nesting stack and clears the winner's edge latch. From then on, only a source of strictly higher priority can raise the request line. Each end-of-interrupt write removes one level. If the processor reads the vector word while no source qualifies, it gets a programmable spurious value and nothing is pushed.

Top module: `vic_top`

## Requirements
- R1: After reset the request output `nirq` is high. The mask, pending and status words read 0, and a vector read returns 0.
- R2: Writing the enable word (address 0x44) sets the mask bit of every source whose data bit is 1. Writing the disable word (0x45) clears those mask bits. Zero bits leave the mask unchanged, and the mask reads back at 0x43.
- R3: Writing the set word (0x47) forces the pending latch of each source whose data bit is 1. Writing the clear word (0x46) clears those latches. The pending word (0x42) shows the raw pending bits whether or not a source is masked.
- R4: A source whose mode bit 4 is 1 is edge-triggered: a rising input edge sets its latch, which stays set after the input falls, and an acknowledge of that source clears it. With mode bit 4 at 0 the source is level-triggered, and its pending bit follows the input.
- R5: A read of the vector word (0x40) returns the vector word (address 0x20 + n) of the pending, unmasked source n with the highest priority in mode bits 2:0, where 7 is highest. On equal priority the lowest source number wins.
- R6: `nirq` is driven low only while some pending, unmasked source has a priority strictly above the priority on top of the nesting stack, or while the stack is empty. An acknowledge pushes the winner onto the stack.
- R7: Each write to the end-of-interrupt word (0x48) pops one level. A lower-priority source that was held off drives `nirq` low again once the levels above it are removed.
- R8: A vector read while no source qualifies for `nirq` returns the spurious word (0x49), pushes nothing, and makes the status word read 0.
- R9: The status word (0x41) reads the source number on top of the stack. It reads 0 when the stack is empty.
- R10: Eight consecutive end-of-interrupt writes always leave the stack empty. An end-of-interrupt write to an empty stack has no effect.
- R11: Mode words (0x00 + n) read back their priority and trigger fields, so a read-modify-write changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Interrupt source lines, synchronous to clk |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| nirq | output | 1 | Active-low interrupt request to the processor |

## Verification
Read data is registered at the edge that samples the read strobe. The bench's monitor therefore compares each queued expected word at the falling edge that follows that sampling edge. An acknowledge, a command write or an end-of-interrupt write changes the stack or latches at that same edge, and `nirq` is registered one edge later. An edge-triggered input reaches `nirq` two edges after the pulse, because its latch adds one register. The bench waits three cycles after every input pulse or command before it checks `nirq`, and checks it at a falling edge, away from the edges where the design changes.

// File: rtl/vic_pkg.sv
// Package: shared address map and field positions for the interrupt controller.
// Assumes word addressing on an 8-bit address bus and at most 32 sources.
package vic_pkg;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned EDGE_BIT = 4;

    localparam logic [ADDR_W-1:0] A_MODE0 = 8'h00;
    localparam logic [ADDR_W-1:0] A_VEC0  = 8'h20;
    localparam logic [ADDR_W-1:0] A_ACK   = 8'h40;
    localparam logic [ADDR_W-1:0] A_STAT  = 8'h41;
    localparam logic [ADDR_W-1:0] A_PEND  = 8'h42;
    localparam logic [ADDR_W-1:0] A_MASK  = 8'h43;
    localparam logic [ADDR_W-1:0] A_ENA   = 8'h44;
    localparam logic [ADDR_W-1:0] A_DIS   = 8'h45;
    localparam logic [ADDR_W-1:0] A_CLR   = 8'h46;
    localparam logic [ADDR_W-1:0] A_SET   = 8'h47;
    localparam logic [ADDR_W-1:0] A_EOI   = 8'h48;
    localparam logic [ADDR_W-1:0] A_SPUR  = 8'h49;
endpackage

// File: rtl/vic_src_bank.sv
// Module: per-source pending latches and mask bits.
// Edge sources latch rising edges; level sources show the input directly.
// A set command wins over a clear in the same cycle.
module vic_src_bank #(
    parameter int unsigned NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_in,
    input  logic [NSRC-1:0] edge_mode,
    input  logic [NSRC-1:0] set_bits,
    input  logic [NSRC-1:0] clr_bits,
    input  logic [NSRC-1:0] ena_bits,
    input  logic [NSRC-1:0] dis_bits,
    output logic [NSRC-1:0] pending,
    output logic [NSRC-1:0] mask
);
    logic [NSRC-1:0] irq_prev;
    logic [NSRC-1:0] latch_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        // Track the previous input level for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) irq_prev[i] <= 1'b0;
            else        irq_prev[i] <= irq_in[i];
        end

        // Pending latch: set by edge or command, cleared by command or acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)
                latch_q[i] <= 1'b0;
            else if (set_bits[i] || (edge_mode[i] && irq_in[i] && !irq_prev[i]))
                latch_q[i] <= 1'b1;
            else if (clr_bits[i])
                latch_q[i] <= 1'b0;
        end

        // Mask bit: enable sets, disable clears.
        always_ff @(posedge clk) begin
            if (!rst_n)           mask[i] <= 1'b0;
            else if (ena_bits[i]) mask[i] <= 1'b1;
            else if (dis_bits[i]) mask[i] <= 1'b0;
        end

        // Visible pending bit.
        assign pending[i] = latch_q[i] || (!edge_mode[i] && irq_in[i]);
    end
endmodule

// File: rtl/vic_arbiter.sv
// Module: combinational priority picker.
// Highest priority wins; the lowest index wins a tie (strict compare, ascending scan).
module vic_arbiter #(
    parameter int unsigned NSRC   = 32,
    parameter int unsigned PRIO_W = 3,
    localparam int unsigned IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]              eligible,
    input  logic [NSRC-1:0][PRIO_W-1:0]  prio,
    output logic                         win_valid,
    output logic [IDX_W-1:0]             win_idx,
    output logic [PRIO_W-1:0]            win_prio
);
    // Scan all sources, keeping the best so far.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        for (int i = 0; i < int'(NSRC); i++) begin
            if (eligible[i] && (!win_valid || prio[i] > win_prio)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_prio  = prio[i];
            end
        end
    end
endmodule

// File: rtl/vic_nest_stack.sv
// Module: nesting stack of (priority, source) pairs.
// Push when full and pop when empty are ignored.
module vic_nest_stack #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned IDX_W  = 5,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic [IDX_W-1:0]  push_idx,
    input  logic              pop,
    output logic [LVL_W-1:0]  level,
    output logic [PRIO_W-1:0] top_prio,
    output logic [IDX_W-1:0]  top_idx
);
    logic [DEPTH-1:0][PRIO_W-1:0] prio_mem;
    logic [DEPTH-1:0][IDX_W-1:0]  idx_mem;
    logic [LVL_W-1:0]             top_slot;

    assign top_slot = (level == 0) ? '0 : level - 1'b1;
    assign top_prio = prio_mem[top_slot[$clog2(DEPTH)-1:0]];
    assign top_idx  = idx_mem[top_slot[$clog2(DEPTH)-1:0]];

    // Level counter and entry storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level    <= '0;
            prio_mem <= '0;
            idx_mem  <= '0;
        end else if (push && level < LVL_W'(DEPTH)) begin
            prio_mem[level[$clog2(DEPTH)-1:0]] <= push_prio;
            idx_mem[level[$clog2(DEPTH)-1:0]]  <= push_idx;
            level <= level + 1'b1;
        end else if (pop && level != 0) begin
            level <= level - 1'b1;
        end
    end
endmodule

// File: rtl/vic_top.sv
// Module: vectored nested-priority interrupt controller top.
// Holds mode and vector words, decodes the register bus, acknowledges on a
// vector read and drives the registered active-low request line.
// Assumes NSRC is a power of two no larger than 32 and one bus access per cycle.
module vic_top
    import vic_pkg::*;
#(
    parameter int unsigned NSRC   = 32,
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned DEPTH  = 8,
    localparam int unsigned IDX_W = $clog2(NSRC),
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_in,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              nirq
);
    logic [NSRC-1:0][PRIO_W-1:0] mode_prio;
    logic [NSRC-1:0]             mode_edge;
    logic [NSRC-1:0][DATA_W-1:0] vec_mem;
    logic [DATA_W-1:0]           spur_q;
    logic                        spur_flag;

    logic [NSRC-1:0]   pending, mask, set_bits, clr_bits, ena_bits, dis_bits, ack_bits;
    logic              win_valid, accept, ack_rd, eoi_wr, sel_mode, sel_vec;
    logic [IDX_W-1:0]  win_idx, top_idx, reg_idx;
    logic [PRIO_W-1:0] win_prio, top_prio;
    logic [LVL_W-1:0]  level;
    logic [DATA_W-1:0] status_val, rd_mux;

    // Bus decode.
    always_comb begin
        sel_mode = bus_addr >= A_MODE0 && bus_addr < A_MODE0 + ADDR_W'(NSRC);
        sel_vec  = bus_addr >= A_VEC0  && bus_addr < A_VEC0  + ADDR_W'(NSRC);
        reg_idx  = sel_vec ? IDX_W'(bus_addr - A_VEC0) : IDX_W'(bus_addr - A_MODE0);
        ack_rd   = bus_rd && bus_addr == A_ACK;
        eoi_wr   = bus_wr && bus_addr == A_EOI;
        ena_bits = (bus_wr && bus_addr == A_ENA) ? NSRC'(bus_wdata) : '0;
        dis_bits = (bus_wr && bus_addr == A_DIS) ? NSRC'(bus_wdata) : '0;
        set_bits = (bus_wr && bus_addr == A_SET) ? NSRC'(bus_wdata) : '0;
        ack_bits = '0;
        if (ack_rd && accept) ack_bits[win_idx] = 1'b1;
        clr_bits = ((bus_wr && bus_addr == A_CLR) ? NSRC'(bus_wdata) : '0) | ack_bits;
    end

    vic_src_bank #(.NSRC(NSRC)) u_bank (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .edge_mode(mode_edge),
        .set_bits(set_bits), .clr_bits(clr_bits), .ena_bits(ena_bits),
        .dis_bits(dis_bits), .pending(pending), .mask(mask)
    );

    vic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
        .eligible(pending & mask), .prio(mode_prio),
        .win_valid(win_valid), .win_idx(win_idx), .win_prio(win_prio)
    );

    vic_nest_stack #(.DEPTH(DEPTH), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(ack_rd && accept), .push_prio(win_prio),
        .push_idx(win_idx), .pop(eoi_wr), .level(level),
        .top_prio(top_prio), .top_idx(top_idx)
    );

    // A winner qualifies only above the current nesting priority.
    assign accept     = win_valid && (level == 0 || win_prio > top_prio);
    assign status_val = (spur_flag || level == 0) ? '0 : DATA_W'(top_idx);

    // Configuration words and the spurious flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_prio <= '0;
            mode_edge <= '0;
            vec_mem   <= '0;
            spur_q    <= '0;
            spur_flag <= 1'b0;
        end else begin
            if (bus_wr && sel_mode) begin
                mode_prio[reg_idx] <= bus_wdata[PRIO_W-1:0];
                mode_edge[reg_idx] <= bus_wdata[EDGE_BIT];
            end
            if (bus_wr && sel_vec) vec_mem[reg_idx] <= bus_wdata;
            if (bus_wr && bus_addr == A_SPUR) spur_q <= bus_wdata;
            if (ack_rd)      spur_flag <= !accept;
            else if (eoi_wr) spur_flag <= 1'b0;
        end
    end

    // Read data selection.
    always_comb begin
        rd_mux = '0;
        if (sel_mode) begin
            rd_mux[PRIO_W-1:0] = mode_prio[reg_idx];
            rd_mux[EDGE_BIT]   = mode_edge[reg_idx];
        end else if (sel_vec) rd_mux = vec_mem[reg_idx];
        else begin
            case (bus_addr)
                A_ACK:   rd_mux = accept ? vec_mem[win_idx] : spur_q;
                A_STAT:  rd_mux = status_val;
                A_PEND:  rd_mux = DATA_W'(pending);
                A_MASK:  rd_mux = DATA_W'(mask);
                A_SPUR:  rd_mux = spur_q;
                default: rd_mux = '0;
            endcase
        end
    end

    // Registered read data and request line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            nirq      <= 1'b1;
        end else begin
            if (bus_rd) bus_rdata <= rd_mux;
            nirq <= !accept;
        end
    end
endmodule

// File: rtl/vic_checker.sv
// Module: assertion checker bound to vic_top.
// Watches bus commands, mask, stack level and request line over time.
module vic_checker
    import vic_pkg::*;
#(
    parameter int unsigned NSRC  = 32,
    parameter int unsigned DEPTH = 8,
    parameter int unsigned LVL_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              nirq,
    input logic [NSRC-1:0]   mask,
    input logic [LVL_W-1:0]  level,
    input logic              accept,
    input logic [DATA_W-1:0] status_val
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH)); // R10
    AST_ACK_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_ACK && accept) |=> level == $past(level) + 1'b1); // R6
    AST_EOI_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EOI && level != 0) |=> level == $past(level) - 1'b1); // R7
    AST_EOI_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EOI && level == 0) |=> level == 0); // R10
    AST_ENA_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_ENA) |=> (mask & NSRC'($past(bus_wdata))) == NSRC'($past(bus_wdata))); // R2
    AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DIS) |=> (mask & NSRC'($past(bus_wdata))) == '0); // R2
    AST_SPUR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_ACK && !accept) |=> status_val == '0); // R8
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |=> nirq); // R6
endmodule

bind vic_top vic_checker #(.NSRC(NSRC), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .nirq(nirq), .mask(mask),
    .level(level), .accept(accept), .status_val(status_val)
);

// File: tb/vic_top_bench.sv
// Bench: scoreboard for vic_top. Read tasks queue expected words; a monitor
// compares each at the falling edge after the read is sampled.
module vic_top_bench;
    import vic_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        nirq;

    int n_chk = 0, n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_d = 1'b0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    vic_top u_vic_top (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nirq(nirq)
    );

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic chk_nirq(input logic exp, input string tag);
        @(negedge clk);
        n_chk++;
        if (nirq !== exp) begin
            n_fail++;
            $display("FAIL %s nirq actual %0b expected %0b", tag, nirq, exp);
        end
    endtask

    task automatic pulse(input int src);
        @(posedge clk); #1; irq_in[src] = 1'b1;
        @(posedge clk); #1; irq_in[src] = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
    endtask

    // Monitor: note reads sampled at each rising edge.
    always @(posedge clk) rd_d <= bus_rd;

    // Monitor: compare read data against the scoreboard.
    always @(negedge clk) begin
        if (rd_d) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (bus_rdata !== e) begin
                n_fail++;
                $display("FAIL %s actual %h expected %h", t, bus_rdata, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk_nirq(1'b1, "R1 reset");
        rd(A_MASK, 32'h0, "R1 mask");
        rd(A_PEND, 32'h0, "R1 pend");
        rd(A_STAT, 32'h0, "R1 status");
        rd(A_ACK,  32'h0, "R1 spurious zero");

        for (int i = 0; i < 32; i++) wr(A_VEC0 + 8'(i), 32'h1000 + i);
        wr(A_SPUR, 32'hDEAD);
        wr(A_MODE0 + 3, 32'h12);
        wr(A_MODE0 + 5, 32'h05);
        wr(A_MODE0 + 7, 32'h15);
        wr(A_MODE0 + 10, 32'h17);
        // R11 read-modify-write of a mode word
        rd(A_MODE0 + 3, 32'h12, "R11 mode readback");
        wr(A_MODE0 + 3, 32'h14);
        rd(A_MODE0 + 3, 32'h14, "R11 mode modified");
        wr(A_MODE0 + 3, 32'h12);
        rd(A_VEC0 + 7, 32'h1007, "R11 vector readback");

        // R2 enable / disable write-one bits
        wr(A_ENA, 32'h0000_04A8);
        rd(A_MASK, 32'h0000_04A8, "R2 enable");
        wr(A_ENA, 32'h0);
        rd(A_MASK, 32'h0000_04A8, "R2 zero bits");
        wr(A_DIS, 32'h0000_0400);
        rd(A_MASK, 32'h0000_00A8, "R2 disable");

        // R3 raw pending of a masked level source
        @(posedge clk); #1 irq_in[20] = 1'b1;
        settle();
        rd(A_PEND, 32'h0010_0000, "R3 raw pending masked");
        chk_nirq(1'b1, "R3 masked no request");
        @(posedge clk); #1 irq_in[20] = 1'b0;
        settle();
        rd(A_PEND, 32'h0, "R4 level follows input");

        // R3 set / clear commands
        wr(A_SET, 32'h8);
        rd(A_PEND, 32'h8, "R3 set command");
        wr(A_CLR, 32'h8);
        rd(A_PEND, 32'h0, "R3 clear command");

        // R4 edge latch, R5 vector, R9 status
        pulse(3);
        rd(A_PEND, 32'h8, "R4 edge latched");
        chk_nirq(1'b0, "R6 request on empty stack");
        rd(A_ACK, 32'h1003, "R5 vector src3");
        rd(A_STAT, 32'd3, "R9 status src3");
        rd(A_PEND, 32'h0, "R4 ack clears latch");
        settle();
        chk_nirq(1'b1, "R6 nothing above top");

        // R5 tie, R6 nesting
        pulse(7);
        @(posedge clk); #1 irq_in[5] = 1'b1;
        settle();
        chk_nirq(1'b0, "R6 higher than top");
        rd(A_ACK, 32'h1005, "R5 tie lowest index");
        rd(A_STAT, 32'd5, "R9 status src5");
        settle();
        chk_nirq(1'b1, "R6 equal priority blocked");
        wr(A_ENA, 32'h400);
        pulse(10);
        chk_nirq(1'b0, "R6 priority 7 preempts");
        rd(A_ACK, 32'h100A, "R5 vector src10");
        rd(A_STAT, 32'd10, "R9 status src10");

        // R7 unwinding
        wr(A_EOI, 32'h0);
        settle();
        chk_nirq(1'b1, "R7 pop to prio5 blocks src7");
        rd(A_STAT, 32'd5, "R7 status after pop");
        @(posedge clk); #1 irq_in[5] = 1'b0;
        wr(A_EOI, 32'h0);
        settle();
        chk_nirq(1'b0, "R7 src7 released");
        rd(A_STAT, 32'd3, "R7 status src3");
        wr(A_EOI, 32'h0);
        rd(A_ACK, 32'h1007, "R7 vector src7");
        rd(A_STAT, 32'd7, "R9 status src7");
        wr(A_EOI, 32'h0);
        settle();
        rd(A_STAT, 32'd0, "R9 empty status");

        // R8 spurious
        rd(A_ACK, 32'hDEAD, "R8 spurious vector");
        rd(A_STAT, 32'd0, "R8 spurious status");
        wr(A_EOI, 32'h0);

        // R10 eight levels then full unwind
        for (int k = 0; k < 8; k++) begin
            wr(A_MODE0 + 8'(12 + k), 32'h10 | k);
            wr(A_ENA, 32'h1 << (12 + k));
            pulse(12 + k);
            rd(A_ACK, 32'h1000 + 12 + k, "R10 nest level vector");
        end
        rd(A_STAT, 32'd19, "R10 status at depth 8");
        pulse(12);
        chk_nirq(1'b1, "R10 full stack blocks");
        for (int k = 0; k < 9; k++) wr(A_EOI, 32'h0);
        settle();
        chk_nirq(1'b0, "R10 unwound after eight pops");
        rd(A_ACK, 32'h100C, "R10 vector after unwind");
        wr(A_EOI, 32'h0);

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule